// File: doc/BRIEF.md
# Hierarchical State Controller with Resumable Super-State

The block is a synchronous controller whose states form a two-level hierarchy. A single grouping state holds five basic sub-states, named A to E here, and sits beside one outer idle state. While the group is active, exactly one of its sub-states is active. The block takes single-cycle event pulses. There are two ways to enter the group. A default entry always starts in sub-state A. A resume entry returns to the sub-state that was active when the group was last left. One leave event removes the machine from the group whatever sub-state it is in, and the block records that sub-state at the same moment.

Inside the group, a step event rotates through the sub-states in the order A, B, C, D, E and back to A. Sub-state C is supervised. If the watched event does not arrive while C is held for a set time, the machine moves to E and emits a one-cycle timeout pulse. That time is 20 ms, counted in clock cycles from a clock-frequency parameter.

Every clock edge is one evaluation step. All events are sampled first, then every next value is computed from the old values, and then all of them are committed together. Updates made in the same step therefore never see each other. Each event pulse applies only to the step in which it is presented.

Top module: `hsm_ctrl`

## Requirements
- R1: The output `active_sub` is one-hot, with bit 0 for A through bit 4 for E. While `super_active` is 1, exactly one bit is set. While it is 0, all bits are 0.
- R2: A synchronous active-high reset makes the outer state active, clears `timeout_pulse`, and marks the group as never having been left.
- R3: In the outer state, `ev_enter_dflt` activates A at the next edge whatever the stored history holds. When it arrives in the same cycle as `ev_enter_hist`, the default entry wins.
- R4: In the outer state, `ev_enter_hist` reactivates the sub-state recorded at the most recent leave. That sub-state can be any of A to E.
- R5: A resume entry made before the group has ever been left activates A.
- R6: From any sub-state, `ev_leave` makes the outer state active at the next edge. In the same edge, the history records the sub-state that was active during the leave cycle, and this value is taken before any step presented in that cycle. The history changes at no other time.
- R7: Inside the group, `ev_leave` has priority over a timeout and over `ev_step` presented in the same cycle. Entry events presented while the group is active have no effect.
- R8: Inside the group, `ev_step` with no leave and no timeout moves A→B→C→D→E→A.
- R9: If C is held for TIMEOUT_CYC consecutive cycles with no `ev_watch` (20 ms of clock), the next edge activates E and raises `timeout_pulse` for exactly that one cycle. The count restarts on every entry into C.
- R10: `ev_watch` presented while in C restarts the timeout count. A timeout expiring in the same cycle as `ev_step` takes priority over the step.
- R11: In the outer state, `ev_step`, `ev_watch` and `ev_leave` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_step | input | 1 | Forward-step event within the group |
| ev_leave | input | 1 | Group leave event |
| ev_enter_dflt | input | 1 | Enter group at the default sub-state |
| ev_enter_hist | input | 1 | Enter group at the remembered sub-state |
| ev_watch | input | 1 | Awaited event supervised in sub-state C |
| active_sub | output | 5 | One-hot active sub-state, bit 0 = A … bit 4 = E |
| super_active | output | 1 | The group is active |
| timeout_pulse | output | 1 | One-cycle pulse on a timeout transition to E |

## Verification
Timeout expiry can land in the same cycle as a step event, and also in the same cycle as a leave event. The bench provokes both cases on purpose. It enters C, waits exactly TIMEOUT_CYC-1 idle cycles, and then presents the step or the leave in the expiry cycle. For the step, the next state must be E with a pulse and not D. For the leave, the next state must be the outer state with no pulse, and a later resume must bring back C. Random stimulus with rare step events in C produces further collisions of this kind, and every cycle is judged against a reference model written from the requirements.

// File: rtl/hsm_pkg.sv
package hsm_pkg;

    localparam int NUM_SUB = 5;

    typedef enum logic [2:0] {
        SUB_A = 3'd0,
        SUB_B = 3'd1,
        SUB_C = 3'd2,
        SUB_D = 3'd3,
        SUB_E = 3'd4
    } sub_e;

    localparam sub_e DFLT_SUB     = SUB_A;
    localparam sub_e TIMED_SUB    = SUB_C;
    localparam sub_e TIMEOUT_DEST = SUB_E;

    typedef struct packed {
        logic in_super;
        sub_e sub;
    } hsm_state_t;

    localparam hsm_state_t RESET_STATE = '{in_super: 1'b0, sub: SUB_A};

    function automatic sub_e next_sub(input sub_e s);
        sub_e r;
        case (s)
            SUB_A:   r = SUB_B;
            SUB_B:   r = SUB_C;
            SUB_C:   r = SUB_D;
            SUB_D:   r = SUB_E;
            default: r = SUB_A;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/hsm_timer.sv
module hsm_timer #(
    parameter int unsigned LIMIT = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic watch,
    output logic expire
);
    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign expire = arm && !watch && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !arm || watch || expire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hsm_history.sv
module hsm_history
    import hsm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic save,
    input  sub_e save_sub,
    output logic valid,
    output sub_e sub
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            sub   <= DFLT_SUB;
        end else if (save) begin
            valid <= 1'b1;
            sub   <= save_sub;
        end
    end
endmodule

// File: rtl/hsm_core.sv
module hsm_core
    import hsm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ev_step,
    input  logic       ev_leave,
    input  logic       ev_dflt,
    input  logic       ev_hist,
    input  logic       expire,
    input  logic       hist_valid,
    input  sub_e       hist_sub,
    output hsm_state_t state,
    output logic       arm_timer,
    output logic       save,
    output sub_e       save_sub,
    output logic       timeout_pulse
);
    hsm_state_t nxt;
    logic       fire;

    assign arm_timer = state.in_super && (state.sub == TIMED_SUB);
    assign save_sub  = state.sub;

    // Phase two: every next value is computed from committed state only.
    always_comb begin
        nxt  = state;
        save = 1'b0;
        fire = 1'b0;
        if (!state.in_super) begin
            if (ev_dflt) begin
                nxt.in_super = 1'b1;
                nxt.sub      = DFLT_SUB;
            end else if (ev_hist) begin
                nxt.in_super = 1'b1;
                nxt.sub      = hist_valid ? hist_sub : DFLT_SUB;
            end
        end else if (ev_leave) begin
            nxt.in_super = 1'b0;
            save         = 1'b1;
        end else if (expire) begin
            nxt.sub = TIMEOUT_DEST;
            fire    = 1'b1;
        end else if (ev_step) begin
            nxt.sub = next_sub(state.sub);
        end
    end

    // Phase three: commit all at once.
    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= RESET_STATE;
            timeout_pulse <= 1'b0;
        end else begin
            state         <= nxt;
            timeout_pulse <= fire;
        end
    end
endmodule

// File: rtl/hsm_ctrl.sv
module hsm_ctrl
    import hsm_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 50_000,
    parameter int unsigned TIMEOUT_MS = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ev_step,
    input  logic               ev_leave,
    input  logic               ev_enter_dflt,
    input  logic               ev_enter_hist,
    input  logic               ev_watch,
    output logic [NUM_SUB-1:0] active_sub,
    output logic               super_active,
    output logic               timeout_pulse
);
    localparam int unsigned RAW_CYC     = (CLK_HZ / 1000) * TIMEOUT_MS;
    localparam int unsigned TIMEOUT_CYC = (RAW_CYC < 1) ? 1 : RAW_CYC;

    hsm_state_t state;
    logic       arm_timer;
    logic       expire;
    logic       save;
    sub_e       save_sub;
    logic       hist_valid;
    sub_e       hist_sub;

    hsm_core i_core (
        .clk          (clk),
        .rst          (rst),
        .ev_step      (ev_step),
        .ev_leave     (ev_leave),
        .ev_dflt      (ev_enter_dflt),
        .ev_hist      (ev_enter_hist),
        .expire       (expire),
        .hist_valid   (hist_valid),
        .hist_sub     (hist_sub),
        .state        (state),
        .arm_timer    (arm_timer),
        .save         (save),
        .save_sub     (save_sub),
        .timeout_pulse(timeout_pulse)
    );

    hsm_timer #(.LIMIT(TIMEOUT_CYC)) i_timer (
        .clk   (clk),
        .rst   (rst),
        .arm   (arm_timer),
        .watch (ev_watch),
        .expire(expire)
    );

    hsm_history i_hist (
        .clk     (clk),
        .rst     (rst),
        .save    (save),
        .save_sub(save_sub),
        .valid   (hist_valid),
        .sub     (hist_sub)
    );

    assign super_active = state.in_super;

    for (genvar g = 0; g < NUM_SUB; g++) begin : g_onehot
        assign active_sub[g] = state.in_super && (state.sub == sub_e'(3'(g)));
    end
endmodule

// File: rtl/hsm_ctrl_chk.sv
module hsm_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       ev_step,
    input logic       ev_leave,
    input logic       ev_enter_dflt,
    input logic       ev_enter_hist,
    input logic       ev_watch,
    input logic [4:0] active_sub,
    input logic       super_active,
    input logic       timeout_pulse
);
    p_single_active_r1: assert property (@(posedge clk) disable iff (rst)
        super_active ? ($countones(active_sub) == 1) : (active_sub == 5'b0));

    p_dflt_entry_r3: assert property (@(posedge clk) disable iff (rst)
        !super_active && ev_enter_dflt |=> super_active && active_sub == 5'b00001);

    p_exit_r6: assert property (@(posedge clk) disable iff (rst)
        super_active && ev_leave |=> !super_active && !timeout_pulse);

    p_entry_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        super_active && !ev_leave && !ev_step && !active_sub[2]
        && (ev_enter_dflt || ev_enter_hist) |=> $stable(active_sub));

    p_step_r8: assert property (@(posedge clk) disable iff (rst)
        super_active && ev_step && !ev_leave && !active_sub[2]
        |=> active_sub == {$past(active_sub[3:0]), $past(active_sub[4])});

    p_timeout_dest_r9: assert property (@(posedge clk) disable iff (rst)
        timeout_pulse |-> active_sub == 5'b10000 && $past(active_sub) == 5'b00100);

    p_watch_hold_r10: assert property (@(posedge clk) disable iff (rst)
        active_sub == 5'b00100 && ev_watch && !ev_leave && !ev_step
        |=> active_sub == 5'b00100 && !timeout_pulse);

    p_outer_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !super_active && !ev_enter_dflt && !ev_enter_hist
        |=> !super_active && !timeout_pulse);
endmodule

bind hsm_ctrl hsm_ctrl_chk i_hsm_ctrl_chk (
    .clk          (clk),
    .rst          (rst),
    .ev_step      (ev_step),
    .ev_leave     (ev_leave),
    .ev_enter_dflt(ev_enter_dflt),
    .ev_enter_hist(ev_enter_hist),
    .ev_watch     (ev_watch),
    .active_sub   (active_sub),
    .super_active (super_active),
    .timeout_pulse(timeout_pulse)
);

// File: tb/test_hsm_ctrl.sv
module test_hsm_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 20;   // 1000 Hz clock, 20 ms

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ev_step = 1'b0, ev_leave = 1'b0, ev_enter_dflt = 1'b0;
    logic       ev_enter_hist = 1'b0, ev_watch = 1'b0;
    logic [4:0] active_sub;
    logic       super_active, timeout_pulse;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    // reference model state
    bit    m_in, m_hv, m_pulse;
    int    m_sub, m_hs, m_cnt;
    string m_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    hsm_ctrl #(.CLK_HZ(1000), .TIMEOUT_MS(20)) i_hsm_ctrl (
        .clk(clk), .rst(rst), .ev_step(ev_step), .ev_leave(ev_leave),
        .ev_enter_dflt(ev_enter_dflt), .ev_enter_hist(ev_enter_hist),
        .ev_watch(ev_watch), .active_sub(active_sub),
        .super_active(super_active), .timeout_pulse(timeout_pulse)
    );

    function automatic logic [4:0] exp_onehot();
        return m_in ? (5'b00001 << m_sub) : 5'b00000;
    endfunction

    task automatic model_reset();
        m_in = 0; m_sub = 0; m_hv = 0; m_hs = 0; m_cnt = 0; m_pulse = 0;
        m_tag = "R2";
    endtask

    // Next values computed from old values only, then committed together.
    task automatic model_step(input bit s, e, d, h, w);
        bit n_in = m_in, n_hv = m_hv, n_p = 0;
        int n_sub = m_sub, n_hs = m_hs, n_cnt = m_cnt;
        string t;
        if (!m_in) begin
            n_cnt = 0;
            if (d) begin n_in = 1; n_sub = 0; t = "R3"; end
            else if (h) begin n_in = 1; n_sub = m_hv ? m_hs : 0; t = m_hv ? "R4" : "R5"; end
            else t = "R11";
        end else if (e) begin
            n_in = 0; n_hv = 1; n_hs = m_sub; n_cnt = 0;
            t = (s || (m_sub == 2)) ? "R7" : "R6";
        end else if (m_sub == 2 && !w && m_cnt == LIMIT-1) begin
            n_sub = 4; n_p = 1; n_cnt = 0; t = s ? "R10" : "R9";
        end else if (s) begin
            n_sub = (m_sub + 1) % 5; n_cnt = 0; t = "R8";
        end else if (m_sub == 2) begin
            n_cnt = w ? 0 : m_cnt + 1; t = w ? "R10" : "R9";
        end else begin
            t = (d || h) ? "R7" : "R1";
        end
        m_in = n_in; m_sub = n_sub; m_hv = n_hv; m_hs = n_hs;
        m_cnt = n_cnt; m_pulse = n_p; m_tag = t;
    endtask

    task automatic compare();
        checks++;
        if (active_sub !== exp_onehot() || super_active !== m_in
            || timeout_pulse !== m_pulse) begin
            failures++;
            $display("FAIL %s: got sub=%b in=%b pulse=%b, expected sub=%b in=%b pulse=%b",
                     m_tag, active_sub, super_active, timeout_pulse,
                     exp_onehot(), m_in, m_pulse);
        end
    endtask

    // drive at a falling edge, judge at the next falling edge
    task automatic cyc(input bit s, e, d, h, w);
        ev_step = s; ev_leave = e; ev_enter_dflt = d; ev_enter_hist = h; ev_watch = w;
        model_step(s, e, d, h, w);
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        compare();                          // R2 reset state
        idle(2);                            // R11 idle outer state
        cyc(1, 1, 0, 0, 1);                 // R11 step/leave/watch in outer state
        cyc(0, 0, 0, 1, 0);                 // R5 resume before any leave -> A
        cyc(1, 0, 0, 0, 0);                 // R8 A->B
        cyc(1, 0, 0, 0, 0);                 // R8 B->C
        idle(LIMIT);                        // R9 timeout to E with pulse
        idle(1);
        cyc(0, 1, 0, 0, 0);                 // R6 leave from E
        cyc(0, 0, 0, 1, 0);                 // R4 resume E
        cyc(1, 0, 0, 0, 0);                 // R8 E->A
        cyc(1, 0, 1, 1, 0);                 // R7 entry events ignored in group
        cyc(1, 0, 0, 0, 0);                 // B->C
        idle(10);
        cyc(0, 0, 0, 0, 1);                 // R10 watch restarts count
        idle(LIMIT);                        // R10 expiry only after full count
        cyc(0, 1, 0, 0, 0);                 // leave from E
        cyc(1, 0, 1, 0, 0);                 // default entry -> A
        cyc(1, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0);                 // now in C
        idle(LIMIT-1);
        cyc(1, 0, 0, 0, 0);                 // R10 timeout beats step
        cyc(0, 1, 0, 0, 0);
        cyc(0, 0, 0, 1, 0);                 // resume E
        cyc(1, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0);                 // C again
        idle(LIMIT-1);
        cyc(0, 1, 0, 0, 0);                 // R7 leave beats timeout
        cyc(0, 0, 0, 1, 0);                 // R6 history holds C
        cyc(1, 0, 0, 0, 0);                 // C->D
        cyc(1, 1, 0, 0, 0);                 // R7 leave beats step, stores D
        cyc(0, 0, 1, 1, 0);                 // R3 default beats resume
        cyc(0, 1, 0, 0, 0);
        cyc(0, 0, 0, 1, 0);                 // R4 resume A
        for (int i = 0; i < 4000; i++) begin
            bit s, e, d, h, w;
            if (m_in) begin
                s = ($urandom % ((m_sub == 2) ? 40 : 6)) == 0;
                e = ($urandom % 30) == 0;
                d = ($urandom % 10) == 0;
                h = ($urandom % 10) == 0;
                w = ($urandom % 25) == 0;
            end else begin
                s = ($urandom % 3) == 0;
                e = ($urandom % 3) == 0;
                d = ($urandom % 4) == 0;
                h = ($urandom % 3) == 0;
                w = ($urandom % 3) == 0;
            end
            cyc(s, e, d, h, w);
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got no completion, expected completion");
            summary();
            $finish;
        end
    end
endmodule